// File: doc/BRIEF.md
# Offset-Tree Absolute-Value Lookup Pipeline

This block turns an array of per-node offsets, held in a tree-shaped layout, into the absolute value of every node. A node's absolute value is the sum of its own offset and the offsets of all of its ancestors, back to the root at index 0. The parent of a node `i > 0` is `i` with its lowest set bit cleared. For example, the chain for node 11 is 11, 10, 8 and 0.

The conversion is an unrolled pipeline of full-array register stages. The first stage captures the incoming offset array. Each following stage completes the nodes one tree level deeper by adding the already finished value of the parent. A new array is accepted on every clock, with no stall. Several clients each own a read port into the last stage. A read port returns the absolute value of the requested node in the same cycle, with no arbitration between clients. The values are signed 32-bit fixed point with 11 fractional bits. Additions wrap in two's complement.

The block is meant to sit behind a register array that is updated elsewhere. Its clients may read values that are a few cycles stale.

Top module: `olt_lookup_pipe`

## Requirements
- R1: A read of node 0 returns exactly the offset of node 0 that was applied `log2(N)+1` clocks earlier.
- R2: A read of node `i` (`0 < i < N`) returns the wrapping 32-bit sum of the offsets of `i` and of every ancestor, taken from one array. The parent is `i & (i-1)`, so node 11 sums 11, 10, 8 and 0, and node 15 sums 15, 14, 12, 8 and 0.
- R3: An array applied before rising edge `k` is returned by the read ports after edge `k+log2(N)` (5 edges in total for N=16), and no earlier.
- R4: The block accepts a different array on every clock. Consecutive arrays come out in order, one clock apart, with no stall and no loss.
- R5: An active-low synchronous reset clears every stage. Until the first array captured after reset reaches the last stage, every in-range read returns 0.
- R6: A read of an index `>= N` (index field width `log2(N)+1` bits) returns 0.
- R7: Each client's port is independent and combinational. A change of index is reflected in the same cycle, and clients reading different nodes in one cycle each get their own correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| offsets_i | input | N*32 | Offset array; node `i` occupies bits `[32*i+31 : 32*i]` |
| rd_idx_i | input | CLIENTS*IDX_W | Per-client node index; client `c` occupies bits `[IDX_W*c+IDX_W-1 : IDX_W*c]` |
| rd_val_o | output | CLIENTS*32 | Per-client absolute value; client `c` occupies bits `[32*c+31 : 32*c]` |

## Verification
The hardest case to reach from the ports is a pipeline that holds a different array in every stage at once. In that state, each read must match the one array that entered exactly `log2(N)+1` clocks earlier. The bench drives a fresh random or directed array on every clock and keeps a history of them, so that every read can be scored against the correct older array. It also applies a reset in the middle of the run, while the stages are full of nonzero data, to show that no stale value leaks through. Directed arrays force two's-complement wrap on the deepest chain (node 15). Random indices mix in-range and out-of-range reads across the clients in the same cycle.

// File: rtl/olt_pkg.sv
// Package: shared fixed-point type and tree-index helpers for the offset-tree
// lookup pipeline. Assumes node indices fit in 32 bits.
package olt_pkg;

    localparam int FIX_W    = 32;
    localparam int FIX_FRAC = 11;

    typedef logic signed [FIX_W-1:0] fix_t;

    // Number of set bits: the tree depth of a node index.
    function automatic int unsigned ones_count(input int unsigned v);
        int unsigned n;
        n = 0;
        for (int b = 0; b < 32; b++) begin
            n += int'(v[b]);
        end
        return n;
    endfunction

    // Parent of a node: clear its lowest set bit (root maps to itself).
    function automatic int unsigned parent_of(input int unsigned v);
        return (v == 0) ? 0 : (v & (v - 1));
    endfunction

endpackage

// File: rtl/olt_sum_stage.sv
// Module: one full-array stage of the lookup pipeline.
// Nodes at tree depth LEVEL add their parent's value, which is already final
// in prev_i. Every other node is forwarded unchanged. LEVEL 0 is the capture
// stage and forwards all nodes. Assumes N is a power of two.
module olt_sum_stage
    import olt_pkg::*;
#(
    parameter int N     = 16,
    parameter int LEVEL = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  fix_t prev_i [N],
    output fix_t next_o [N]
);

    fix_t nxt_d [N];

    // Per-node next value: parent sum at this depth, else pass-through.
    for (genvar i = 0; i < N; i++) begin : g_node
        localparam int unsigned DEPTH = ones_count(i);
        localparam int unsigned PAR   = parent_of(i);
        if (LEVEL > 0 && DEPTH == LEVEL) begin : g_add
            assign nxt_d[i] = prev_i[i] + prev_i[PAR];
        end else begin : g_pass
            assign nxt_d[i] = prev_i[i];
        end
    end

    // Stage register: cleared by reset, loaded every cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) next_o[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) next_o[i] <= nxt_d[i];
        end
    end

endmodule

// File: rtl/olt_read_port.sv
// Module: one client's read-only port into the final stage.
// Combinational select of the requested node; an index >= N yields zero.
// Assumes IDX_W > log2(N).
module olt_read_port
    import olt_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 5
) (
    input  fix_t             table_i [N],
    input  logic [IDX_W-1:0] idx_i,
    output fix_t             val_o
);

    localparam int SEL_W = $clog2(N);

    // Select the node, or zero when out of range.
    always_comb begin
        val_o = '0;
        if ({{(32-IDX_W){1'b0}}, idx_i} < 32'(N)) begin
            val_o = table_i[idx_i[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/olt_lookup_pipe.sv
// Module: top of the offset-tree absolute-value lookup pipeline.
// Captures the offset array every cycle. log2(N) further stages complete
// one tree depth each, and CLIENTS independent ports read the last stage.
// Assumes N is a power of two, N >= 2.
module olt_lookup_pipe
    import olt_pkg::*;
#(
    parameter int N       = 16,
    parameter int CLIENTS = 3,
    parameter int IDX_W   = $clog2(N) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N*FIX_W-1:0]       offsets_i,
    input  logic [CLIENTS*IDX_W-1:0] rd_idx_i,
    output logic [CLIENTS*FIX_W-1:0] rd_val_o
);

    localparam int LEVELS = $clog2(N);
    localparam int STAGES = LEVELS + 1;

    fix_t link [STAGES+1][N];
    fix_t rd_val [CLIENTS];

    // Unpack the flat input into the stage-0 array.
    for (genvar i = 0; i < N; i++) begin : g_unpack
        assign link[0][i] = fix_t'(offsets_i[i*FIX_W +: FIX_W]);
    end

    // Chain of full-array stages: capture, then one per tree depth.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        olt_sum_stage #(
            .N     (N),
            .LEVEL (s)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .prev_i (link[s]),
            .next_o (link[s+1])
        );
    end

    // One dedicated read port per client.
    for (genvar c = 0; c < CLIENTS; c++) begin : g_client
        olt_read_port #(
            .N     (N),
            .IDX_W (IDX_W)
        ) u_port (
            .table_i (link[STAGES]),
            .idx_i   (rd_idx_i[c*IDX_W +: IDX_W]),
            .val_o   (rd_val[c])
        );
        assign rd_val_o[c*FIX_W +: FIX_W] = rd_val[c];
    end

endmodule

// File: rtl/olt_lookup_chk.sv
// Module: assertion checker for olt_lookup_pipe, attached by bind.
// Relates each read port to the input array seen log2(N)+1 edges before.
module olt_lookup_chk
    import olt_pkg::*;
#(
    parameter int N       = 16,
    parameter int CLIENTS = 3,
    parameter int IDX_W   = $clog2(N) + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N*FIX_W-1:0]       offsets_i,
    input logic [CLIENTS*IDX_W-1:0] rd_idx_i,
    input logic [CLIENTS*FIX_W-1:0] rd_val_o
);

    localparam int STAGES = $clog2(N) + 1;

    int unsigned warm;

    // Count edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 0;
        else if (warm < STAGES) warm <= warm + 1;
    end

    function automatic logic [FIX_W-1:0] chain_sum(input logic [N*FIX_W-1:0] offs,
                                                   input int unsigned idx);
        logic [FIX_W-1:0] acc;
        int unsigned j;
        acc = '0;
        j = idx;
        for (int k = 0; k <= $clog2(N); k++) begin
            acc = acc + offs[j*FIX_W +: FIX_W];
            if (j == 0) break;
            j = j & (j - 1);
        end
        return acc;
    endfunction

    for (genvar c = 0; c < CLIENTS; c++) begin : g_chk
        wire [IDX_W-1:0] idx = rd_idx_i[c*IDX_W +: IDX_W];
        wire [FIX_W-1:0] val = rd_val_o[c*FIX_W +: FIX_W];
        wire in_rng = ({{(32-IDX_W){1'b0}}, idx} < 32'(N));

        a_r1_root_value: assert property (@(posedge clk) disable iff (!rst_n)
            (warm >= STAGES && idx == '0) |-> val == $past(offsets_i[FIX_W-1:0], STAGES));

        a_r2_path_sum: assert property (@(posedge clk) disable iff (!rst_n)
            (warm >= STAGES && in_rng) |-> val == chain_sum($past(offsets_i, STAGES), 32'(idx)));

        a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (warm < STAGES && in_rng) |-> val == '0);

        a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
            !in_rng |-> val == '0);
    end

endmodule

bind olt_lookup_pipe olt_lookup_chk #(
    .N       (N),
    .CLIENTS (CLIENTS),
    .IDX_W   (IDX_W)
) u_olt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .offsets_i (offsets_i),
    .rd_idx_i  (rd_idx_i),
    .rd_val_o  (rd_val_o)
);

// File: tb/olt_lookup_pipe_tb.sv
// Bench: drives a new offset array every clock (directed, then random with a
// fixed seed) and scores each read against a history-based model.
module olt_lookup_pipe_tb_top;

    localparam int PERIOD  = 10;
    localparam int N       = 16;
    localparam int CLIENTS = 3;
    localparam int IDX_W   = 5;
    localparam int LAT     = 5;
    localparam int NCYC    = 60;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [N*32-1:0]          offsets;
    logic [CLIENTS*IDX_W-1:0] rd_idx;
    logic [CLIENTS*32-1:0]    rd_val;

    logic [31:0] hist [NCYC][N];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    olt_lookup_pipe #(.N(N), .CLIENTS(CLIENTS), .IDX_W(IDX_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .offsets_i (offsets),
        .rd_idx_i  (rd_idx),
        .rd_val_o  (rd_val)
    );

    always #(PERIOD/2) clk = ~clk;

    // Expected absolute value: own offset plus every ancestor (clear lowest bit).
    function automatic logic [31:0] expect_val(input int t, input int idx);
        logic [31:0] acc;
        int j;
        if (idx >= N || t < 0) return 32'd0;
        acc = 32'd0;
        j = idx;
        while (1) begin
            acc = acc + hist[t][j];
            if (j == 0) break;
            j = j & (j - 1);
        end
        return acc;
    endfunction

    task automatic check_ports(input int t, input bit second);
        for (int c = 0; c < CLIENTS; c++) begin
            int idx;
            logic [31:0] got, exp;
            string tag;
            idx = int'(rd_idx[c*IDX_W +: IDX_W]);
            got = rd_val[c*32 +: 32];
            exp = (t >= LAT) ? expect_val(t - LAT, idx) : 32'd0;
            if (idx >= N) tag = "R6";
            else if (t < LAT) tag = "R5";
            else if (second) tag = "R7";
            else if (idx == 0) tag = "R1";
            else tag = "R2 (R3 latency, R4 throughput)";
            checks++;
            if (got !== exp) begin
                failures++;
                $display("FAIL %s t=%0d client=%0d idx=%0d actual=%08h expected=%08h",
                         tag, t, c, idx, got, exp);
            end
        end
    endtask

    task automatic fill_history();
        for (int t = 0; t < NCYC; t++) begin
            for (int i = 0; i < N; i++) begin
                case (t)
                    0: hist[t][i] = 32'(i + 1);                 // ramp: node 15 -> 54
                    1: hist[t][i] = 32'h7FFF_FFFF;              // wrap on long chains
                    2: hist[t][i] = 32'hFFFF_F800;              // -1.0 in Q11
                    3: hist[t][i] = (i == 0) ? 32'h800 : 32'd0; // root only
                    default: hist[t][i] = $urandom;
                endcase
            end
        end
    endtask

    // One run: release reset, then a new array and new indices every clock.
    task automatic run_phase();
        int pick [6] = '{0, 1, 11, 15, 16, 31};
        fill_history();
        @(negedge clk);
        for (int t = 0; t < NCYC; t++) begin
            rst_n = 1'b1;
            for (int i = 0; i < N; i++) offsets[i*32 +: 32] = hist[t][i];
            rd_idx[0 +: IDX_W] = IDX_W'(pick[t % 6]);
            for (int c = 1; c < CLIENTS; c++) rd_idx[c*IDX_W +: IDX_W] = IDX_W'($urandom % 32);
            #1;
            check_ports(t, 1'b0);
            // R7: a changed index answers within the same cycle.
            for (int c = 0; c < CLIENTS; c++) rd_idx[c*IDX_W +: IDX_W] = IDX_W'($urandom % 20);
            #1;
            check_ports(t, 1'b1);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        offsets = '0;
        rd_idx = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        run_phase();
        // Mid-run reset with full stages: R5 requires zeros afterwards.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        run_phase();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule